// File: doc/BRIEF.md
# Dual Gated Timer/Counter with Byte Auto-Reload

This block holds two independent 16-bit count channels. Each channel is read and written as a low byte and a high byte. A shared clock divider produces one tick every `PRESCALE` clock cycles, and by default `PRESCALE` is 12. A channel advances either on these ticks or on falling edges of its own count pin. It advances only while its run bit is set and its gate permits.

A channel has two modes. In the first, the full 16-bit value wraps from all ones to zero. In the second, only the low byte counts, and on wrap it reloads from the high byte.

Each wrap sets a sticky overflow flag for that channel. The wrap of channel 1 also produces a one-cycle pulse meant to pace a serial port's bit clock.

Software reaches the block through a plain register bus. A write takes effect on the clock edge where `bus_wr` is high. A read is combinational from `bus_addr`. The bus has no handshake and never stalls, so there is no back-pressure anywhere. The count pins and gate pins are plain level inputs.

Top module: `gated_timer_pair`

## Requirements
- R1: After reset, every register reads 0x00, `ovf_flag` is 0 and `baud_tick` is 0.
- R2: With the edge-select bit clear, a running channel whose gate is open advances by exactly k in any window of k·`PRESCALE` consecutive clock edges.
- R3: With edge-select set (mode bit 1 of the channel's nibble), the channel advances by one for each falling edge of its `cnt_pin`. The count pin is sampled on every clock, and the new value is readable two edges after the pin falls. A rising edge has no effect.
- R4: A channel holds its value while its run bit is clear. When its gate-enable mode bit (bit 2 of the nibble) is set, it also holds while its `gate_pin` is low.
- R5: With reload-select clear (mode bit 0 of the nibble), the 16-bit count goes from 0xFFFF to 0x0000 and the channel's overflow flag is set on that edge.
- R6: With reload-select set, an advance from a low byte of 0xFF loads the high byte into the low byte and sets the overflow flag. The high byte does not change.
- R7: Control register bits 4+i hold overflow flag i, and bits 0 and 1 hold the run bits. Writing the control register loads the flags, so writing 0 clears a flag. An overflow in the same cycle takes precedence over the write.
- R8: A bus write to either count byte of a channel takes effect even when an advance falls on the same edge, and it cancels that advance.
- R9: `baud_tick` pulses for exactly one cycle after each overflow of channel 1. The pulse coincides with that channel's flag becoming set.
- R10: Addresses 0 to 3 are the channel 0 low, channel 0 high, channel 1 low and channel 1 high bytes. Address 4 is the mode register, with channel 0 in bits 2:0 and channel 1 in bits 6:4; its unused bits read 0. Address 5 is control. Every other address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data |
| cnt_pin | input | 2 | External count input per channel |
| gate_pin | input | 2 | External gate input per channel |
| ovf_flag | output | 2 | Sticky overflow flag per channel |
| baud_tick | output | 1 | One-cycle pulse on channel 1 overflow |

## Verification
The bench builds the block with `PRESCALE` = 4, so one tick period is a few cycles. This makes it cheap to sweep windows of whole tick periods, wrap across full 16-bit and 8-bit boundaries, and run dozens of reload periods in one test. Reload sweeps cover high-byte values down to a period of a single tick, where an overflow happens on every tick. Counts and pulse totals are compared with values the bench works out as quotients and remainders of the tick count. Gate pins are driven between edges, which opens windows of exact edge counts independent of the divider's phase.

// File: rtl/tc_pkg.sv
`timescale 1ns/1ps
package tc_pkg;
  localparam int NCH     = 2;
  localparam int ADDR_W  = 3;
  localparam int BAUD_CH = 1;
  localparam logic [ADDR_W-1:0] MODE_ADDR = 3'd4;
  localparam logic [ADDR_W-1:0] CTRL_ADDR = 3'd5;

  // per-channel mode nibble, low three bits
  typedef struct packed {
    logic gate_en;      // bit 2: honour gate pin
    logic edge_mode;    // bit 1: count pin falling edges
    logic reload_mode;  // bit 0: 8-bit reload from high byte
  } tc_mode_t;
endpackage

// File: rtl/tc_prescaler.sv
`timescale 1ns/1ps
module tc_prescaler #(
  parameter int PRESCALE = 12
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int PS_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  logic [PS_W-1:0] div_q;

  assign tick = (div_q == PS_W'(PRESCALE - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    div_q <= '0;
    else if (tick) div_q <= '0;
    else           div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/tc_edge_detect.sv
`timescale 1ns/1ps
module tc_edge_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic fall
);
  logic now_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      now_q  <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      now_q  <= pin;
      prev_q <= now_q;
    end
  end

  assign fall = prev_q & ~now_q;
endmodule

// File: rtl/tc_channel.sv
`timescale 1ns/1ps
module tc_channel import tc_pkg::*; #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              fall,
  input  logic              run,
  input  logic              gate_pin,
  input  tc_mode_t          mode,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] lo_q,
  output logic [BYTE_W-1:0] hi_q,
  output logic              ovf_evt
);
  logic gate_open, adv, lo_full, hi_full;

  assign gate_open = run & (~mode.gate_en | gate_pin);
  assign adv       = gate_open & (mode.edge_mode ? fall : tick) & ~(wr_lo | wr_hi);
  assign lo_full   = &lo_q;
  assign hi_full   = &hi_q;
  assign ovf_evt   = adv & lo_full & (mode.reload_mode | hi_full);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      if (wr_lo)                           lo_q <= wdata;
      else if (adv && mode.reload_mode && lo_full) lo_q <= hi_q;
      else if (adv)                        lo_q <= lo_q + 1'b1;

      if (wr_hi)                                     hi_q <= wdata;
      else if (adv && !mode.reload_mode && lo_full)  hi_q <= hi_q + 1'b1;
    end
  end
endmodule

// File: rtl/gated_timer_pair.sv
`timescale 1ns/1ps
module gated_timer_pair import tc_pkg::*; #(
  parameter int PRESCALE = 12,
  parameter int BYTE_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [2:0]        bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  input  logic [1:0]        cnt_pin,
  input  logic [1:0]        gate_pin,
  output logic [1:0]        ovf_flag,
  output logic              baud_tick
);
  logic                          tick;
  logic [NCH-1:0]                fall;
  logic [NCH-1:0]                ovf_evt;
  logic [NCH-1:0][BYTE_W-1:0]    cnt_lo, cnt_hi;
  tc_mode_t [NCH-1:0]            mode_q;
  logic [NCH-1:0]                run_q;
  logic [NCH-1:0]                ovf_q;
  logic                          baud_q;
  logic                          wr_mode, wr_ctrl;

  assign wr_mode = bus_wr && (bus_addr == MODE_ADDR);
  assign wr_ctrl = bus_wr && (bus_addr == CTRL_ADDR);

  tc_prescaler #(.PRESCALE(PRESCALE)) u_div (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    tc_edge_detect u_edge (
      .clk(clk), .rst_n(rst_n), .pin(cnt_pin[g]), .fall(fall[g])
    );
    tc_channel #(.BYTE_W(BYTE_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .fall     (fall[g]),
      .run      (run_q[g]),
      .gate_pin (gate_pin[g]),
      .mode     (mode_q[g]),
      .wr_lo    (bus_wr && (bus_addr == ADDR_W'(2*g))),
      .wr_hi    (bus_wr && (bus_addr == ADDR_W'(2*g + 1))),
      .wdata    (bus_wdata),
      .lo_q     (cnt_lo[g]),
      .hi_q     (cnt_hi[g]),
      .ovf_evt  (ovf_evt[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      run_q  <= '0;
      ovf_q  <= '0;
      baud_q <= 1'b0;
    end else begin
      if (wr_mode)
        for (int i = 0; i < NCH; i++) mode_q[i] <= tc_mode_t'(bus_wdata[4*i +: 3]);
      if (wr_ctrl) run_q <= bus_wdata[NCH-1:0];
      for (int i = 0; i < NCH; i++) begin
        if (ovf_evt[i])   ovf_q[i] <= 1'b1;
        else if (wr_ctrl) ovf_q[i] <= bus_wdata[4+i];
      end
      baud_q <= ovf_evt[BAUD_CH];
    end
  end

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NCH; i++) begin
      if (bus_addr == ADDR_W'(2*i))     bus_rdata = cnt_lo[i];
      if (bus_addr == ADDR_W'(2*i + 1)) bus_rdata = cnt_hi[i];
    end
    if (bus_addr == MODE_ADDR)
      for (int i = 0; i < NCH; i++) bus_rdata[4*i +: 3] = mode_q[i];
    if (bus_addr == CTRL_ADDR)
      for (int i = 0; i < NCH; i++) begin
        bus_rdata[i]   = run_q[i];
        bus_rdata[4+i] = ovf_q[i];
      end
  end

  assign ovf_flag  = ovf_q;
  assign baud_tick = baud_q;
endmodule

// File: rtl/tc_checker.sv
`timescale 1ns/1ps
module tc_checker #(
  parameter int BYTE_W = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   bus_wr,
  input logic [5:0]             mode_bits,
  input logic [1:0]             run_q,
  input logic [1:0][BYTE_W-1:0] cnt_lo,
  input logic [1:0][BYTE_W-1:0] cnt_hi,
  input logic [1:0]             ovf_flag,
  input logic                   baud_tick
);
  logic [1:0][2*BYTE_W-1:0] full;

  for (genvar i = 0; i < 2; i++) begin : g_prop
    assign full[i] = {cnt_hi[i], cnt_lo[i]};

    // R2: in 16-bit mode without bus writes the count moves by at most one
    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_wr && !mode_bits[3*i]) |=>
        (full[i] == $past(full[i])) || (full[i] == $past(full[i]) + 1'b1));

    // R4: a stopped channel keeps its value
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_wr && !run_q[i]) |=> $stable(full[i]));

    // R5: 16-bit wrap raises the flag
    p_rollover_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_wr && !mode_bits[3*i] && cnt_lo[i] == '1 && cnt_hi[i] == '1)
        ##1 (cnt_lo[i] == '0 && cnt_hi[i] == '0) |-> ovf_flag[i]);

    // R6: reload copies the high byte, which stays, and raises the flag
    p_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_wr && mode_bits[3*i] && cnt_lo[i] == '1) ##1 (cnt_lo[i] != '1) |->
        (cnt_lo[i] == $past(cnt_hi[i])) && $stable(cnt_hi[i]) && ovf_flag[i]);
  end

  // R9: baud pulse is single-cycle and accompanies a set flag
  p_tick_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    baud_tick |-> ovf_flag[1]);
  p_tick_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    baud_tick |=> !baud_tick);
endmodule

bind gated_timer_pair tc_checker #(.BYTE_W(BYTE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .mode_bits (mode_q),
  .run_q     (run_q),
  .cnt_lo    (cnt_lo),
  .cnt_hi    (cnt_hi),
  .ovf_flag  (ovf_flag),
  .baud_tick (baud_tick)
);

// File: tb/tb_gated_timer_pair.sv
`timescale 1ns/1ps
module tb_gated_timer_pair;
  localparam int PS = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [1:0] cnt_pin = '0;
  logic [1:0] gate_pin = '0;
  logic [1:0] ovf_flag;
  logic       baud_tick;

  int total = 0;
  int bad = 0;
  int baud_cnt = 0;
  int baud_dbl = 0;
  logic baud_prev = 1'b0;

  always #2 clk = ~clk;

  gated_timer_pair #(.PRESCALE(PS), .BYTE_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cnt_pin(cnt_pin),
    .gate_pin(gate_pin), .ovf_flag(ovf_flag), .baud_tick(baud_tick)
  );

  always @(negedge clk) begin
    if (baud_tick) baud_cnt++;
    if (baud_tick && baud_prev) baud_dbl++;
    baud_prev <= baud_tick;
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  // hold gate i open for exactly n clock edges
  task automatic open_for(input int i, input int n);
    @(negedge clk); gate_pin[i] = 1'b1;
    repeat (n) @(posedge clk);
    @(negedge clk); gate_pin[i] = 1'b0;
  endtask

  task automatic reload_sweep(input logic [7:0] h, input int n);
    logic [7:0] v;
    int per;
    per = 256 - h;
    wr(5, 8'h00);
    wr(4, 8'h50);              // ch1: gate-enable + reload, timer ticks
    wr(3, h); wr(2, h);
    wr(5, 8'h02);              // run ch1, flags cleared
    baud_cnt = 0; baud_dbl = 0;
    open_for(1, n * PS);
    repeat (3) @(posedge clk);
    check("R9 pulse count", baud_cnt, n / per);
    check("R9 single cycle", baud_dbl, 0);
    rd(2, v); check("R6 low after reload", v, (h + (n % per)) & 8'hFF);
    rd(3, v); check("R6 high unchanged", v, h);
    check("R6 flag", ovf_flag[1], (n >= per) ? 1 : 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] a, b, v;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    for (int r = 0; r < 8; r++) begin
      rd(r[2:0], v); check("R1 reset register", v, 0);
    end
    check("R1 reset flags", ovf_flag, 0);
    check("R1 reset baud", baud_tick, 0);

    // R10 register map sweep, channels stopped
    for (int x = 0; x < 256; x += 7) begin
      wr(0, x[7:0]); wr(1, ~x[7:0]); wr(2, x[7:0] ^ 8'h5A); wr(3, x[7:0] + 8'd3);
      wr(4, x[7:0]);
      rd(0, v); check("R10 ch0 low", v, x & 8'hFF);
      rd(1, v); check("R10 ch0 high", v, ~x & 8'hFF);
      rd(2, v); check("R10 ch1 low", v, (x ^ 8'h5A) & 8'hFF);
      rd(3, v); check("R10 ch1 high", v, (x + 3) & 8'hFF);
      rd(4, v); check("R10 mode", v, x & 8'h77);
      rd(6, v); check("R10 unused addr", v, 0);
    end

    // R7 flags loaded by control write
    wr(5, 8'h30);
    check("R7 flag set by write", ovf_flag, 2'b11);
    rd(5, v); check("R7 control readback", v, 8'h30);
    wr(5, 8'h00);
    check("R7 flag cleared by write", ovf_flag, 2'b00);

    // R2 timer windows, ch0 free running
    wr(4, 8'h00); wr(0, 8'h00); wr(1, 8'h00);
    wr(5, 8'h01);
    for (int k = 1; k <= 9; k += 2) begin
      rd(0, a);
      repeat (k * PS) @(posedge clk);
      rd(0, b);
      check("R2 ticks per window", (b - a) & 8'hFF, k);
    end

    // R4 gating
    wr(5, 8'h00); wr(4, 8'h04); wr(0, 8'h10); wr(1, 8'h00);
    wr(5, 8'h01);
    rd(0, a); repeat (6 * PS) @(posedge clk); rd(0, b);
    check("R4 gate low holds", b, a);
    open_for(0, 6 * PS);
    rd(0, b); check("R4 gate high counts", (b - a) & 8'hFF, 6);
    wr(4, 8'h00); wr(5, 8'h00);
    rd(0, a); repeat (5 * PS) @(posedge clk); rd(0, b);
    check("R4 run clear holds", b, a);

    // R5 16-bit wrap
    wr(4, 8'h04); wr(0, 8'hFD); wr(1, 8'hFF); wr(5, 8'h01);
    open_for(0, 2 * PS);
    rd(0, v); check("R5 low before wrap", v, 8'hFF);
    rd(1, v); check("R5 high before wrap", v, 8'hFF);
    check("R5 flag before wrap", ovf_flag[0], 0);
    open_for(0, 2 * PS);
    rd(0, v); check("R5 low after wrap", v, 8'h01);
    rd(1, v); check("R5 high after wrap", v, 8'h00);
    check("R5 flag after wrap", ovf_flag[0], 1);
    check("R9 no baud from ch0", baud_cnt, 0);
    wr(5, 8'h01);
    check("R7 flag cleared after wrap", ovf_flag[0], 0);

    // R3 edge counting on ch1
    wr(5, 8'h00); wr(4, 8'h20); wr(2, 8'h00); wr(3, 8'h00);
    wr(5, 8'h02);
    for (int n = 1; n <= 12; n++) begin
      @(negedge clk); cnt_pin[1] = 1'b1;
      repeat (2) @(posedge clk);
      @(negedge clk); cnt_pin[1] = 1'b0;
      repeat (2) @(posedge clk);
      rd(2, v); check("R3 falling edge count", v, n);
    end
    @(negedge clk); cnt_pin[1] = 1'b1;
    repeat (4) @(posedge clk);
    rd(2, v); check("R3 rising edge ignored", v, 12);
    // R4 gate closes edge counting
    wr(4, 8'h60); gate_pin[1] = 1'b0;
    @(negedge clk); cnt_pin[1] = 1'b0;
    repeat (4) @(posedge clk);
    rd(2, v); check("R4 gated edge ignored", v, 12);

    // R6 / R9 reload sweeps
    reload_sweep(8'hFC, 40);
    reload_sweep(8'hF0, 40);
    reload_sweep(8'hFE, 41);
    reload_sweep(8'hFF, 30);
    reload_sweep(8'h00, 20);

    // R8 write beats advance on the same edge
    wr(5, 8'h00); wr(4, 8'h00); wr(1, 8'h00);
    wr(5, 8'h01);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 3'd0; bus_wdata = 8'h55;
    for (int j = 0; j < 3 * PS; j++) begin
      @(posedge clk); @(negedge clk);
      check("R8 write wins", bus_rdata, 8'h55);
    end
    bus_wr = 1'b0;
    #1;
    rd(1, v); check("R8 high untouched", v, 8'h00);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule